// File: doc/BRIEF.md
# Two-Level Page Table Walker

A hardware walker that turns a 32-bit linear address into a physical address by reading a page directory and, when needed, a page table, through a simple memory port. Each walk starts from a request. The request carries the linear address, a store flag, the 4 KB-aligned frame of the directory and a large-page enable. The walker answers with the physical address, a large-page flag and the combined entry bits, or with a fault and its class. Permission decisions are left to a downstream block, which consumes the combined bits.

The memory port performs plain reads and locked compare-and-swap operations. For a compare-and-swap, the port returns the value it found, and the write happens only if that value equals the compare value. The walker sets the accessed bit of a directory entry that it descends through. It sets the accessed bit, and on stores the dirty bit, of the final entry. A lost compare-and-swap on the directory step repeats that step. A lost compare-and-swap on the final entry restarts the walk. Large pages relocate eight entry bits into physical address bits 39:32, which gives a 40-bit physical address.

Top module: `pt2_walker`

## Requirements
- R1: After reset the walker is idle: busy_o, done_o, fault_o, fault_rsvd_o, big_page_o, mem_req_o, mem_cas_o, pa_o and ent_o are all zero.
- R2: The first read of every walk is at {dir_frame_i, laddr[31:22], 2'b00}.
- R3: The table entry is read at {directory entry[31:12], laddr[21:12], 2'b00}.
- R4: A directory or table entry with bit 0 (present) clear ends the walk with fault_o and fault_rsvd_o = 0 (class not-present).
- R5: A directory entry is a final 4 MB entry only when its bit 7 is set and pse_en_i was high at the request. The resulting address is pa_o = {pde[20:13], pde[31:22], laddr[21:0]} with big_page_o = 1. With pse_en_i low, bit 7 is ignored and the walk proceeds to a table.
- R6: A 4 MB entry with bit 21 set ends the walk with fault_o and fault_rsvd_o = 1 (class reserved), without writing memory.
- R7: When a walk descends through a directory entry whose bit 5 (accessed) is clear, the walker issues a compare-and-swap at the directory entry address, with that entry as the compare value and bit 5 set in the write value. The port returns the current value. If that value differs from the compare value, the walker re-reads the entry and tries again. A memory request is held with a stable address until mem_ack_i.
- R8: For a 4 KB page, ent_o bit 2 (user) and bit 1 (write) are the AND of those bits in the directory and table entries. The other bits of ent_o come from the table entry.
- R9: On success the final entry gains bit 5, and on a store also bit 6 (dirty). The walker writes these by compare-and-swap only if they are not yet set, and ent_o shows them. When the access is not a store and the entry's bit 6 was clear, ent_o bit 1 is cleared.
- R10: If the compare-and-swap on the final entry returns a different value, the walk restarts with a fresh directory read. The result then reflects the new entry value.
- R11: For a 4 KB page, pa_o = {8'h00, pte[31:12], laddr[11:0]} and big_page_o = 0.
- R12: busy_o rises in the cycle after a request is accepted while idle. It stays high through a single-cycle done_o or fault_o, never both at once, and falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk (taken when idle) |
| req_laddr_i | input | 32 | Linear address |
| req_store_i | input | 1 | Access is a store |
| pse_en_i | input | 1 | Large pages enabled |
| dir_frame_i | input | 20 | Directory frame (base address bits 31:12) |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle success pulse |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_rsvd_o | output | 1 | Fault class: 1 reserved, 0 not present |
| pa_o | output | 40 | Physical address |
| big_page_o | output | 1 | Result is a 4 MB page |
| ent_o | output | 32 | Combined final entry bits |
| mem_req_o | output | 1 | Memory request |
| mem_cas_o | output | 1 | Request is compare-and-swap |
| mem_addr_o | output | 32 | Entry address |
| mem_cmp_o | output | 32 | Compare value |
| mem_wdata_o | output | 32 | Swap value |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 32 | Read value, or the value found by the swap |

## Verification
Several properties hold on every cycle and are checked continuously. The done and fault pulses are single-cycle, exclusive and framed by busy_o. A memory request stays stable until its acknowledge. Every compare-and-swap adds only accessed or dirty bits, and a large-page result can only appear with large pages enabled. Other behaviours only show up in the bench's directed scenarios, against a memory model that can spoil a swap: the address arithmetic, the PSE-36 relocation, the user/write combination, the fault classes, the accessed/dirty write-backs and both retry paths. The retry paths are confirmed by counting accesses at the entry addresses.

// File: rtl/pt2_pkg.sv
package pt2_pkg;
  localparam int unsigned LA_W   = 32;
  localparam int unsigned ENT_W  = 32;
  localparam int unsigned FRM_W  = 20;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned HI_W   = 8;
  localparam int unsigned PA_W   = LA_W + HI_W;
  localparam int unsigned OFF4K  = LA_W - FRM_W;
  localparam int unsigned OFF4M  = OFF4K + IDX_W;

  localparam int unsigned B_P    = 0;
  localparam int unsigned B_RW   = 1;
  localparam int unsigned B_US   = 2;
  localparam int unsigned B_A    = 5;
  localparam int unsigned B_D    = 6;
  localparam int unsigned B_PS   = 7;
  localparam int unsigned B_RSV  = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PDE_RD, ST_PDE_CAS, ST_PTE_RD, ST_FIN_CHK, ST_FIN_CAS, ST_RESP
  } st_e;
endpackage

// File: rtl/pt2_addr.sv
module pt2_addr
  import pt2_pkg::*;
(
  input  logic [FRM_W-1:0] dir_frame_i,
  input  logic [IDX_W-1:0] dir_idx_i,
  input  logic [FRM_W-1:0] tbl_frame_i,
  input  logic [IDX_W-1:0] tbl_idx_i,
  output logic [LA_W-1:0]  pde_addr_o,
  output logic [LA_W-1:0]  pte_addr_o
);
  assign pde_addr_o = {dir_frame_i, dir_idx_i, 2'b00};
  assign pte_addr_o = {tbl_frame_i, tbl_idx_i, 2'b00};
endmodule

// File: rtl/pt2_result.sv
module pt2_result
  import pt2_pkg::*;
(
  input  logic [ENT_W-1:0] pde_i,
  input  logic [ENT_W-1:0] pte_i,
  input  logic [OFF4M-1:0] laddr_lo_i,
  input  logic             big_i,
  input  logic             store_i,
  output logic [ENT_W-1:0] raw_o,
  output logic [ENT_W-1:0] upd_o,
  output logic             need_wr_o,
  output logic [ENT_W-1:0] ent_o,
  output logic [PA_W-1:0]  pa_o
);
  logic [ENT_W-1:0] set_mask, comb;

  always_comb begin
    set_mask         = '0;
    set_mask[B_A]    = 1'b1;
    set_mask[B_D]    = store_i;
    raw_o            = big_i ? pde_i : pte_i;
    upd_o            = raw_o | set_mask;
    need_wr_o        = |(set_mask & ~raw_o);
    comb             = upd_o;
    if (!big_i) begin
      comb[B_US] = upd_o[B_US] & pde_i[B_US];
      comb[B_RW] = upd_o[B_RW] & pde_i[B_RW];
    end
    if (!store_i && !raw_o[B_D]) comb[B_RW] = 1'b0;
    ent_o = comb;
    if (big_i)
      pa_o = {pde_i[B_RSV-1 -: HI_W], pde_i[ENT_W-1:OFF4M], laddr_lo_i};
    else
      pa_o = {{HI_W{1'b0}}, pte_i[ENT_W-1:OFF4K], laddr_lo_i[OFF4K-1:0]};
  end
endmodule

// File: rtl/pt2_walker.sv
module pt2_walker
  import pt2_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LA_W-1:0]  req_laddr_i,
  input  logic             req_store_i,
  input  logic             pse_en_i,
  input  logic [FRM_W-1:0] dir_frame_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic             fault_rsvd_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             big_page_o,
  output logic [ENT_W-1:0] ent_o,
  output logic             mem_req_o,
  output logic             mem_cas_o,
  output logic [LA_W-1:0]  mem_addr_o,
  output logic [ENT_W-1:0] mem_cmp_o,
  output logic [ENT_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [ENT_W-1:0] mem_rdata_i
);
  st_e              st_q;
  logic [LA_W-1:0]  laddr_q;
  logic [FRM_W-1:0] frame_q;
  logic             store_q, pse_q, big_q;
  logic [ENT_W-1:0] pde_q, pte_q;
  logic [LA_W-1:0]  pde_addr, pte_addr;
  logic [ENT_W-1:0] raw, upd, ent_c, pde_a;
  logic [PA_W-1:0]  pa_c;
  logic             need_wr;

  pt2_addr i_addr (
    .dir_frame_i (frame_q),
    .dir_idx_i   (laddr_q[LA_W-1 -: IDX_W]),
    .tbl_frame_i (pde_q[ENT_W-1:OFF4K]),
    .tbl_idx_i   (laddr_q[OFF4M-1:OFF4K]),
    .pde_addr_o  (pde_addr),
    .pte_addr_o  (pte_addr)
  );

  pt2_result i_res (
    .pde_i      (pde_q),
    .pte_i      (pte_q),
    .laddr_lo_i (laddr_q[OFF4M-1:0]),
    .big_i      (big_q),
    .store_i    (store_q),
    .raw_o      (raw),
    .upd_o      (upd),
    .need_wr_o  (need_wr),
    .ent_o      (ent_c),
    .pa_o       (pa_c)
  );

  always_comb begin
    pde_a      = pde_q;
    pde_a[B_A] = 1'b1;
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign mem_req_o = (st_q == ST_PDE_RD) || (st_q == ST_PDE_CAS) ||
                     (st_q == ST_PTE_RD) || (st_q == ST_FIN_CAS);
  assign mem_cas_o = (st_q == ST_PDE_CAS) || (st_q == ST_FIN_CAS);

  always_comb begin
    mem_addr_o  = '0;
    mem_cmp_o   = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_PDE_RD:  mem_addr_o = pde_addr;
      ST_PTE_RD:  mem_addr_o = pte_addr;
      ST_PDE_CAS: begin
        mem_addr_o  = pde_addr;
        mem_cmp_o   = pde_q;
        mem_wdata_o = pde_a;
      end
      ST_FIN_CAS: begin
        mem_addr_o  = big_q ? pde_addr : pte_addr;
        mem_cmp_o   = raw;
        mem_wdata_o = upd;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      laddr_q      <= '0;
      frame_q      <= '0;
      store_q      <= 1'b0;
      pse_q        <= 1'b0;
      big_q        <= 1'b0;
      pde_q        <= '0;
      pte_q        <= '0;
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      fault_rsvd_o <= 1'b0;
      pa_o         <= '0;
      big_page_o   <= 1'b0;
      ent_o        <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          laddr_q <= req_laddr_i;
          frame_q <= dir_frame_i;
          store_q <= req_store_i;
          pse_q   <= pse_en_i;
          big_q   <= 1'b0;
          st_q    <= ST_PDE_RD;
        end
        ST_PDE_RD: if (mem_ack_i) begin
          pde_q <= mem_rdata_i;
          if (!mem_rdata_i[B_P]) begin
            fault_o <= 1'b1; fault_rsvd_o <= 1'b0; st_q <= ST_RESP;
          end else if (mem_rdata_i[B_PS] && pse_q) begin
            if (mem_rdata_i[B_RSV]) begin
              fault_o <= 1'b1; fault_rsvd_o <= 1'b1; st_q <= ST_RESP;
            end else begin
              big_q <= 1'b1; st_q <= ST_FIN_CHK;
            end
          end else begin
            st_q <= mem_rdata_i[B_A] ? ST_PTE_RD : ST_PDE_CAS;
          end
        end
        ST_PDE_CAS: if (mem_ack_i) begin
          if (mem_rdata_i == pde_q) begin
            pde_q <= pde_a;
            st_q  <= ST_PTE_RD;
          end else begin
            st_q  <= ST_PDE_RD;  // entry moved: re-read it
          end
        end
        ST_PTE_RD: if (mem_ack_i) begin
          pte_q <= mem_rdata_i;
          if (!mem_rdata_i[B_P]) begin
            fault_o <= 1'b1; fault_rsvd_o <= 1'b0; st_q <= ST_RESP;
          end else begin
            st_q <= ST_FIN_CHK;
          end
        end
        ST_FIN_CHK: begin
          if (need_wr) st_q <= ST_FIN_CAS;
          else begin
            done_o <= 1'b1; pa_o <= pa_c; ent_o <= ent_c;
            big_page_o <= big_q; st_q <= ST_RESP;
          end
        end
        ST_FIN_CAS: if (mem_ack_i) begin
          if (mem_rdata_i == raw) begin
            done_o <= 1'b1; pa_o <= pa_c; ent_o <= ent_c;
            big_page_o <= big_q; st_q <= ST_RESP;
          end else begin
            big_q <= 1'b0;       // full restart from the directory
            st_q  <= ST_PDE_RD;
          end
        end
        ST_RESP: begin
          done_o  <= 1'b0;
          fault_o <= 1'b0;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R12
  AST_END_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> busy_o); // R12
  AST_END_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> (!busy_o && !done_o && !fault_o)); // R12
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_cas_o))); // R7
  AST_CAS_ADDS_AD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cas_o |-> (((mem_wdata_o ^ mem_cmp_o) & ~32'h0000_0060) == 32'h0 &&
                   (mem_wdata_o & ~mem_cmp_o) != 32'h0)); // R9
  AST_BIG_NEEDS_PSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && big_page_o) |-> pse_q); // R5
endmodule

// File: tb/test_pt2_walker.sv
module test_pt2_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, pse_en = 1'b0;
  logic [31:0] req_laddr = '0;
  logic [19:0] dir_frame = '0;
  logic        busy, done, fault, fault_rsvd, big_page;
  logic [39:0] pa;
  logic [31:0] ent;
  logic        mem_req, mem_cas, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_cmp, mem_wdata, mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] spoil_addr = '0;
  logic        spoil_en = 1'b0;
  logic [31:0] watch_addr = '0;
  int          watch_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt2_walker i_pt2_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_laddr_i(req_laddr),
    .req_store_i(req_store), .pse_en_i(pse_en), .dir_frame_i(dir_frame),
    .busy_o(busy), .done_o(done), .fault_o(fault), .fault_rsvd_o(fault_rsvd),
    .pa_o(pa), .big_page_o(big_page), .ent_o(ent), .mem_req_o(mem_req),
    .mem_cas_o(mem_cas), .mem_addr_o(mem_addr), .mem_cmp_o(mem_cmp),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] cur;
    if (mem_req && !mem_ack) begin
      cur = rd(mem_addr);
      if (mem_cas && spoil_en && mem_addr == spoil_addr) begin
        cur = cur | 32'h200;
        mem[mem_addr] = cur;
        spoil_en <= 1'b0;
      end
      if (mem_addr == watch_addr) watch_cnt <= watch_cnt + 1;
      if (mem_cas && cur == mem_cmp) mem[mem_addr] = mem_wdata;
      mem_rdata <= cur;
      mem_ack   <= 1'b1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] la, input logic st, input logic pse);
    int t;
    @(negedge clk);
    req_laddr = la; req_store = st; pse_en = pse; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 busy after accept", busy, 1);
    t = 0;
    while (!done && !fault && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) chk("R12 walk timeout", 1, 0);
    chk("R12 done/fault exclusive", done & fault, 0);
  endtask

  task automatic expect_idle_next();
    @(negedge clk);
    chk("R12 idle after pulse", {busy, done, fault}, 3'b000);
  endtask

  localparam logic [31:0] DIRB = 32'h0001_0000;

  function automatic logic [31:0] pde_at(input logic [31:0] la);
    return DIRB + {20'h0, la[31:22], 2'b00};
  endfunction

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 fault", fault, 0);
    chk("R1 rsvd", fault_rsvd, 0); chk("R1 big", big_page, 0);
    chk("R1 mem_req", mem_req, 0); chk("R1 mem_cas", mem_cas, 0);
    chk("R1 pa", pa, 0); chk("R1 ent", ent, 0);
  endtask

  task automatic t_small_load();
    logic [31:0] la = 32'h0040_3ABC;
    mem.delete();
    mem[pde_at(la)] = 32'h0002_0007;                      // P RW US, A clear
    mem[32'h0002_0000 + 32'h3*4] = 32'h1234_5027;         // P RW US A, D clear
    walk(la, 1'b0, 1'b0);
    chk("R11 small done", done, 1);
    chk("R11 small pa", pa, 40'h00_1234_5ABC);
    chk("R11 small big", big_page, 0);
    chk("R9 clean load clears RW", ent, 32'h1234_5025);
    chk("R7 pde accessed set", rd(pde_at(la)), 32'h0002_0027);
    chk("R3 pte untouched", rd(32'h0002_000C), 32'h1234_5027);
    expect_idle_next();
  endtask

  task automatic t_small_store_and();
    logic [31:0] la = 32'h0080_1004;
    mem.delete();
    mem[pde_at(la)] = 32'h0003_0023;                      // P RW A, no US
    mem[32'h0003_0000 + 32'h1*4] = 32'h0ABC_D007;         // P RW US
    walk(la, 1'b1, 1'b1);
    chk("R9 store done", done, 1);
    chk("R9 pte A|D written", rd(32'h0003_0004), 32'h0ABC_D067);
    chk("R8 US anded", ent, 32'h0ABC_D063);
    chk("R11 store pa", pa, 40'h00_0ABC_D004);
    expect_idle_next();
  endtask

  task automatic t_not_present();
    logic [31:0] la = 32'h00C0_0000;
    mem.delete();
    walk(la, 1'b0, 1'b0);
    chk("R4 pde np fault", fault, 1);
    chk("R4 pde np class", fault_rsvd, 0);
    expect_idle_next();
    mem[pde_at(la)] = 32'h0004_0021;
    walk(la, 1'b0, 1'b0);
    chk("R4 pte np fault", fault, 1);
    chk("R4 pte np class", fault_rsvd, 0);
    expect_idle_next();
  endtask

  task automatic t_big();
    logic [31:0] la = 32'h0D12_3456;
    mem.delete();
    mem[pde_at(la)] = 32'hC014_A0C7;  // frame C0/.., bits20:13=A5, PS P RW US D
    walk(la, 1'b0, 1'b1);
    chk("R5 big done", done, 1);
    chk("R5 big flag", big_page, 1);
    chk("R5 big pa", pa, 40'hA5_C012_3456);
    chk("R9 big A set", rd(pde_at(la)), 32'hC014_A0E7);
    chk("R9 big ent", ent, 32'hC014_A0E7);
    expect_idle_next();
  endtask

  task automatic t_big_rsvd();
    logic [31:0] la = 32'h1000_0000;
    mem.delete();
    mem[pde_at(la)] = 32'h0020_0087;
    walk(la, 1'b1, 1'b1);
    chk("R6 rsvd fault", fault, 1);
    chk("R6 rsvd class", fault_rsvd, 1);
    chk("R6 no write", rd(pde_at(la)), 32'h0020_0087);
    expect_idle_next();
  endtask

  task automatic t_pse_off();
    logic [31:0] la = 32'h1440_2010;
    mem.delete();
    mem[pde_at(la)] = 32'h0005_00A7;                      // PS set, A set
    mem[32'h0005_0000 + 32'h2*4] = 32'h7777_7067;
    watch_addr = pde_at(la); watch_cnt = 0;
    walk(la, 1'b0, 1'b0);
    chk("R5 pse off walks table", big_page, 0);
    chk("R5 pse off pa", pa, 40'h00_7777_7010);
    chk("R2 one pde access", watch_cnt, 1);
    expect_idle_next();
  endtask

  task automatic t_pde_retry();
    logic [31:0] la = 32'h1800_5000;
    mem.delete();
    mem[pde_at(la)] = 32'h0006_0007;
    mem[32'h0006_0000 + 32'h5*4] = 32'h0BAD_0067;
    watch_addr = pde_at(la); watch_cnt = 0;
    spoil_addr = pde_at(la); spoil_en = 1'b1;
    walk(la, 1'b0, 1'b0);
    chk("R7 retry done", done, 1);
    chk("R7 pde accesses", watch_cnt, 4);
    chk("R7 pde final", rd(pde_at(la)), 32'h0006_0227);
    chk("R7 pa", pa, 40'h00_0BAD_0000);
    expect_idle_next();
  endtask

  task automatic t_fin_restart();
    logic [31:0] la = 32'h2000_7123;
    mem.delete();
    mem[pde_at(la)] = 32'h0008_0027;
    mem[32'h0008_0000 + 32'h7*4] = 32'h0CAF_E027;
    watch_addr = pde_at(la); watch_cnt = 0;
    spoil_addr = 32'h0008_001C; spoil_en = 1'b1;
    walk(la, 1'b1, 1'b0);
    chk("R10 restart done", done, 1);
    chk("R10 pde reread", watch_cnt, 2);
    chk("R10 pte final", rd(32'h0008_001C), 32'h0CAF_E267);
    chk("R10 ent new", ent, 32'h0CAF_E267);
    expect_idle_next();
  endtask

  initial begin
    dir_frame = DIRB[31:12];
    #1;
    t_reset();
    #(CLK_PERIOD*2);
    rst_n = 1'b1;
    t_small_load();
    t_small_store_and();
    t_not_present();
    t_big();
    t_big_rsvd();
    t_pse_off();
    t_pde_retry();
    t_fin_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule